// File: doc/BRIEF.md
# Kernel Control Register File

This block is the host-facing control window of a compute kernel. A host talks to it over a 32-bit AXI4-Lite slave port. Through it the host starts the kernel and polls or takes interrupts on its completion. It also reads two 64-bit capability words that the core exports and sets a 64-bit memory base address. A separate 64-bit scratch register lets a debug agent exchange a value with the host.

Configuration registers inside the core are written indirectly. The host first writes a configuration address, then a configuration value. The value write produces a single strobe on the core side that carries both the address and the value. The core reports completion with done, idle and ready levels. When it signals ready, the block either clears the start request or keeps it armed, depending on the auto-restart setting.

All register updates, and the AXI handshakes, advance only in cycles where the clock-enable input is high. The reset is asynchronous and active low, and its release is expected to be synchronous to `clk`.

Top module: `kctl_regfile`

## Requirements
- R1: A write is accepted, with awready and wready high together, only in a cycle where clk_en, awvalid and wvalid are all high and no write response is pending. Read data is registered and rvalid rises on the edge that completes the address handshake. The block holds one read and one write at a time. A response stays valid and unchanged until it is taken, and bresp and rresp are always 2'b00.
- R2: The control word at offset 0x00 reads start in bit 0, done in bit 1, idle in bit 2, ready in bit 3 and auto-restart in bit 7, and reads zero in every other bit. Writing 1 to bit 0 sets start, and writing 0 to bit 0 leaves start unchanged. Bit 7 takes the written value. The core_start output is the start bit.
- R3: The done bit sets in any enabled cycle where core_done is high. A host read of offset 0x00 returns the current value and then clears the bit. If core_done is high in the same cycle as that read, the set wins.
- R4: In an enabled cycle where core_ready is high, start is reloaded with the auto-restart bit. A host write of 1 to start in that same cycle takes priority.
- R5: The device capability word reads at 0x10 (bits 31:0) and 0x14 (bits 63:32). The second capability word reads at 0x1C (low) and 0x20 (high). Writes to these four offsets have no effect.
- R6: A write to 0x28 stores the configuration address and a write to 0x2C stores the configuration value. The 0x2C write makes cfg_wr_valid high for exactly one enabled cycle, starting on the edge after the write handshake, with cfg_wr_addr and cfg_wr_data carrying the stored pair. Offsets 0x28 and 0x2C read as zero.
- R7: The memory base is read-write at 0x40 (low) and 0x44 (high) and drives mem_base. The scratch register is read-write at 0x34 (low) and 0x38 (high). The memory base changes only through a write handshake.
- R8: Bit 0 of offset 0x04 is the global interrupt enable and bit 0 of offset 0x08 is the interrupt enable; both read back. Bit 0 of offset 0x0C is set on a rising edge of core_done while the interrupt enable is 1, and writing 1 to it clears it. If a rising edge arrives in the same cycle as that clear, the set wins. irq is the status bit ANDed with the global enable.
- R9: Each written byte lane is updated only if its wstrb bit is set. The start and auto-restart fields, and the enable and status bits, use lane 0.
- R10: Reads at any other address, including addresses that are not word aligned, return zero with an OKAY response. Writes to such addresses change nothing.
- R11: While clk_en is low, no register changes: start, done, interrupt status and memory base hold, and no handshake completes.
- R12: After reset, start, auto-restart, done, the enables, interrupt status, configuration address, value and strobe, scratch and memory base are all zero, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable for all state and handshakes |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| core_start | output | 1 | Start request to the core |
| core_done | input | 1 | Core completion level |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core ready for a new start |
| dev_caps | input | 64 | Device capability word |
| isa_caps | input | 64 | Second capability word |
| cfg_wr_valid | output | 1 | Configuration write strobe |
| cfg_wr_addr | output | 32 | Configuration write address |
| cfg_wr_data | output | 32 | Configuration write value |
| mem_base | output | 64 | Memory base address |
| irq | output | 1 | Interrupt level |

## Verification
The hardest cases to reach are same-cycle collisions: a host write of start on the edge where core_ready reloads it, and a clearing read of the control word while core_done is still high. The stimulus holds core_ready high across a whole control-word write and samples core_start on the cycle right after the handshake. It holds core_done high across two control-word reads, and across a write-one-to-clear of the interrupt status, to show that the set takes priority and that a level cannot raise a second edge. The byte-strobe logic is covered by sweeping all sixteen strobe patterns.

// File: rtl/kctl_pkg.sv
package kctl_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned LANE_N = REG_W / 8;

  // byte offsets of the host-visible words
  localparam int unsigned OFF_CTRL     = 'h00;
  localparam int unsigned OFF_GIE      = 'h04;
  localparam int unsigned OFF_IEN      = 'h08;
  localparam int unsigned OFF_IST      = 'h0C;
  localparam int unsigned OFF_DEV_LO   = 'h10;
  localparam int unsigned OFF_DEV_HI   = 'h14;
  localparam int unsigned OFF_ISA_LO   = 'h1C;
  localparam int unsigned OFF_ISA_HI   = 'h20;
  localparam int unsigned OFF_CFG_ADR  = 'h28;
  localparam int unsigned OFF_CFG_VAL  = 'h2C;
  localparam int unsigned OFF_SCR_LO   = 'h34;
  localparam int unsigned OFF_SCR_HI   = 'h38;
  localparam int unsigned OFF_MEM_LO   = 'h40;
  localparam int unsigned OFF_MEM_HI   = 'h44;

  // control word field positions
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_DONE  = 1;
  localparam int unsigned CB_IDLE  = 2;
  localparam int unsigned CB_READY = 3;
  localparam int unsigned CB_AUTO  = 7;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [REG_W-1:0] merge_lanes(
    input logic [REG_W-1:0]  old_v,
    input logic [REG_W-1:0]  new_v,
    input logic [LANE_N-1:0] lanes
  );
    logic [REG_W-1:0] r;
    r = old_v;
    for (int b = 0; b < int'(LANE_N); b++) begin
      if (lanes[b]) r[8*b +: 8] = new_v[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/kctl_wr_chan.sv
module kctl_wr_chan
  import kctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [REG_W-1:0]  wdata,
  input  logic [LANE_N-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic [LANE_N-1:0] wr_lanes
);

  logic bvalid_q, bvalid_d;

  // address and data are taken together, and only with no response pending
  assign wr_fire  = clk_en & awvalid & wvalid & ~bvalid_q;
  assign awready  = wr_fire;
  assign wready   = wr_fire;
  assign wr_addr  = awaddr;
  assign wr_data  = wdata;
  assign wr_lanes = wstrb;

  always_comb begin
    bvalid_d = bvalid_q;
    if (clk_en) begin
      if (wr_fire)              bvalid_d = 1'b1;
      else if (bvalid_q & bready) bvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bvalid_q <= 1'b0;
    else        bvalid_q <= bvalid_d;
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;

endmodule

// File: rtl/kctl_rd_chan.sv
module kctl_rd_chan
  import kctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [REG_W-1:0]  rdata,
  output logic [1:0]        rresp,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  rd_value
);

  logic             rvalid_q, rvalid_d;
  logic [REG_W-1:0] rdata_q, rdata_d;

  assign rd_fire = clk_en & arvalid & ~rvalid_q;
  assign arready = rd_fire;
  assign rd_addr = araddr;

  always_comb begin
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (clk_en) begin
      if (rd_fire) begin
        rvalid_d = 1'b1;
        rdata_d  = rd_value;
      end else if (rvalid_q & rready) begin
        rvalid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

endmodule

// File: rtl/kctl_regs.sv
module kctl_regs
  import kctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CAP_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [LANE_N-1:0] wr_lanes,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_value,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  input  logic [CAP_W-1:0]  dev_caps,
  input  logic [CAP_W-1:0]  isa_caps,
  output logic              core_start,
  output logic              cfg_wr_valid,
  output logic [REG_W-1:0]  cfg_wr_addr,
  output logic [REG_W-1:0]  cfg_wr_data,
  output logic [2*REG_W-1:0] mem_base,
  output logic              irq
);

  localparam int unsigned WIDE_W = 2 * REG_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic              start_q, start_d, auto_q, auto_d;
  logic              done_q, done_d, dprev_q, dprev_d;
  logic              gie_q, gie_d, ien_q, ien_d, ist_q, ist_d;
  logic              cval_q, cval_d;
  logic [REG_W-1:0]  cadr_q, cadr_d, cdat_q, cdat_d;
  logic [WIDE_W-1:0] scr_q, scr_d, mem_q, mem_d;
  logic              lane0;

  assign lane0 = wr_lanes[0];

  // next-state
  always_comb begin
    start_d = start_q;  auto_d = auto_q;
    done_d  = done_q;   dprev_d = dprev_q;
    gie_d   = gie_q;    ien_d  = ien_q;   ist_d = ist_q;
    cval_d  = cval_q;   cadr_d = cadr_q;  cdat_d = cdat_q;
    scr_d   = scr_q;    mem_d  = mem_q;
    if (clk_en) begin
      cval_d  = 1'b0;
      dprev_d = core_done;
      // start: core reload first, host write of 1 overrides
      if (core_ready) start_d = auto_q;
      if (wr_fire && hit(wr_addr, OFF_CTRL) && lane0) begin
        if (wr_data[CB_START]) start_d = 1'b1;
        auto_d = wr_data[CB_AUTO];
      end
      // done: read clears, core level sets (set wins)
      if (rd_fire && hit(rd_addr, OFF_CTRL)) done_d = 1'b0;
      if (core_done) done_d = 1'b1;
      if (wr_fire && hit(wr_addr, OFF_GIE) && lane0) gie_d = wr_data[0];
      if (wr_fire && hit(wr_addr, OFF_IEN) && lane0) ien_d = wr_data[0];
      if (wr_fire && hit(wr_addr, OFF_IST) && lane0 && wr_data[0]) ist_d = 1'b0;
      if (core_done && !dprev_q && ien_q) ist_d = 1'b1;
      if (wr_fire && hit(wr_addr, OFF_CFG_ADR))
        cadr_d = merge_lanes(cadr_q, wr_data, wr_lanes);
      if (wr_fire && hit(wr_addr, OFF_CFG_VAL)) begin
        cdat_d = merge_lanes(cdat_q, wr_data, wr_lanes);
        cval_d = 1'b1;
      end
      if (wr_fire && hit(wr_addr, OFF_SCR_LO))
        scr_d[REG_W-1:0] = merge_lanes(scr_q[REG_W-1:0], wr_data, wr_lanes);
      if (wr_fire && hit(wr_addr, OFF_SCR_HI))
        scr_d[WIDE_W-1:REG_W] = merge_lanes(scr_q[WIDE_W-1:REG_W], wr_data, wr_lanes);
      if (wr_fire && hit(wr_addr, OFF_MEM_LO))
        mem_d[REG_W-1:0] = merge_lanes(mem_q[REG_W-1:0], wr_data, wr_lanes);
      if (wr_fire && hit(wr_addr, OFF_MEM_HI))
        mem_d[WIDE_W-1:REG_W] = merge_lanes(mem_q[WIDE_W-1:REG_W], wr_data, wr_lanes);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;  auto_q <= 1'b0;
      done_q  <= 1'b0;  dprev_q <= 1'b0;
      gie_q   <= 1'b0;  ien_q  <= 1'b0;  ist_q <= 1'b0;
      cval_q  <= 1'b0;  cadr_q <= '0;    cdat_q <= '0;
      scr_q   <= '0;    mem_q  <= '0;
    end else begin
      start_q <= start_d;  auto_q <= auto_d;
      done_q  <= done_d;   dprev_q <= dprev_d;
      gie_q   <= gie_d;    ien_q  <= ien_d;   ist_q <= ist_d;
      cval_q  <= cval_d;   cadr_q <= cadr_d;  cdat_q <= cdat_d;
      scr_q   <= scr_d;    mem_q  <= mem_d;
    end
  end

  // read mux
  always_comb begin
    rd_value = '0;
    if (hit(rd_addr, OFF_CTRL)) begin
      rd_value[CB_START] = start_q;
      rd_value[CB_DONE]  = done_q;
      rd_value[CB_IDLE]  = core_idle;
      rd_value[CB_READY] = core_ready;
      rd_value[CB_AUTO]  = auto_q;
    end
    else if (hit(rd_addr, OFF_GIE))    rd_value[0] = gie_q;
    else if (hit(rd_addr, OFF_IEN))    rd_value[0] = ien_q;
    else if (hit(rd_addr, OFF_IST))    rd_value[0] = ist_q;
    else if (hit(rd_addr, OFF_DEV_LO)) rd_value = dev_caps[REG_W-1:0];
    else if (hit(rd_addr, OFF_DEV_HI)) rd_value = dev_caps[CAP_W-1:REG_W];
    else if (hit(rd_addr, OFF_ISA_LO)) rd_value = isa_caps[REG_W-1:0];
    else if (hit(rd_addr, OFF_ISA_HI)) rd_value = isa_caps[CAP_W-1:REG_W];
    else if (hit(rd_addr, OFF_SCR_LO)) rd_value = scr_q[REG_W-1:0];
    else if (hit(rd_addr, OFF_SCR_HI)) rd_value = scr_q[WIDE_W-1:REG_W];
    else if (hit(rd_addr, OFF_MEM_LO)) rd_value = mem_q[REG_W-1:0];
    else if (hit(rd_addr, OFF_MEM_HI)) rd_value = mem_q[WIDE_W-1:REG_W];
  end

  assign core_start   = start_q;
  assign cfg_wr_valid = cval_q;
  assign cfg_wr_addr  = cadr_q;
  assign cfg_wr_data  = cdat_q;
  assign mem_base     = mem_q;
  assign irq          = ist_q & gie_q;

endmodule

// File: rtl/kctl_regfile.sv
module kctl_regfile
  import kctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              core_start,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  input  logic [63:0]       dev_caps,
  input  logic [63:0]       isa_caps,
  output logic              cfg_wr_valid,
  output logic [31:0]       cfg_wr_addr,
  output logic [31:0]       cfg_wr_data,
  output logic [63:0]       mem_base,
  output logic              irq
);

  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [REG_W-1:0]  wr_data, rd_value;
  logic [LANE_N-1:0] wr_lanes;

  kctl_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lanes(wr_lanes)
  );

  kctl_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_value(rd_value)
  );

  kctl_regs #(.ADDR_W(ADDR_W), .CAP_W(64)) u_regs (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lanes(wr_lanes),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_value(rd_value),
    .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready),
    .dev_caps(dev_caps), .isa_caps(isa_caps),
    .core_start(core_start), .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .mem_base(mem_base), .irq(irq)
  );

endmodule

// File: rtl/kctl_regfile_chk.sv
module kctl_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_en,
  input logic        s_awready,
  input logic        s_bvalid,
  input logic        s_bready,
  input logic        s_arvalid,
  input logic        s_arready,
  input logic        s_rvalid,
  input logic        s_rready,
  input logic [31:0] s_rdata,
  input logic        core_start,
  input logic        cfg_wr_valid,
  input logic [63:0] mem_base,
  input logic        irq
);

  // R1: read data follows the address handshake on the next edge
  p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && s_arready |=> s_rvalid);

  // R1: a read response is held until taken
  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !(s_rready && clk_en) |=> s_rvalid && $stable(s_rdata));

  // R1: a write response is held until taken
  p_wr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !(s_bready && clk_en) |=> s_bvalid);

  // R6: strobe lasts one enabled cycle
  p_cfg_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_valid && clk_en |=> !cfg_wr_valid);

  // R6: strobe only follows a write handshake
  p_cfg_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_wr_valid) |-> $past(s_awready));

  // R7: memory base moves only through a write
  p_mem_only_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_awready |=> $stable(mem_base));

  // R11: nothing moves with the enable low
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(core_start) && $stable(mem_base) && $stable(irq)
                && $stable(cfg_wr_valid));

endmodule

bind kctl_regfile kctl_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
  .s_awready(s_awready), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_arvalid(s_arvalid), .s_arready(s_arready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .core_start(core_start), .cfg_wr_valid(cfg_wr_valid),
  .mem_base(mem_base), .irq(irq)
);

// File: tb/sim_kctl_regfile.sv
module sim_kctl_regfile;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] DEV = 64'h1122_3344_5566_7788;
  localparam logic [63:0] ISA = 64'h99AA_BBCC_DDEE_F001;

  logic        clk, rst_n, clk_en;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic [11:0] awaddr, araddr;
  logic [31:0] wdata, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic        arvalid, arready, rvalid, rready;
  logic        core_start, core_done, core_idle, core_ready;
  logic        cfg_wr_valid, irq;
  logic [31:0] cfg_wr_addr, cfg_wr_data;
  logic [63:0] mem_base;

  int n_checks = 0;
  int n_err    = 0;
  int cfg_pulses = 0;
  bit finished = 0;
  logic        snap_cval, snap_start;
  logic [31:0] snap_cadr, snap_cdat;

  kctl_regfile u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
    .core_ready(core_ready), .dev_caps(DEV), .isa_caps(ISA),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .mem_base(mem_base), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (cfg_wr_valid) cfg_pulses++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1; bready = 1'b0;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    snap_cval = cfg_wr_valid; snap_cadr = cfg_wr_addr; snap_cdat = cfg_wr_data;
    snap_start = core_start;
    check("R1 bvalid after write", {63'd0, bvalid}, 64'd1);
    check("R1 bresp okay", {62'd0, bresp}, 64'd0);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic axi_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1; rready = 1'b0;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 1'b0;
    check("R1 rvalid one cycle after handshake", {63'd0, rvalid}, 64'd1);
    check("R1 rresp okay", {62'd0, rresp}, 64'd0);
    d = rdata;
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); core_ready = 1'b1;
    @(negedge clk); core_ready = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  function automatic logic [31:0] reset_view(input int off);
    case (off)
      'h00: return 32'h4;           // idle only
      'h10: return DEV[31:0];
      'h14: return DEV[63:32];
      'h1C: return ISA[31:0];
      'h20: return ISA[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rv, pre, d_in, expv;
    int p0;
    rst_n = 1'b0; clk_en = 1'b1;
    awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0;
    awaddr = '0; araddr = '0; wdata = '0; wstrb = '0;
    core_done = 0; core_idle = 1; core_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state at the ports
    check("R12 core_start", {63'd0, core_start}, 64'd0);
    check("R12 mem_base", mem_base, 64'd0);
    check("R12 cfg strobe/addr/data", {cfg_wr_valid, cfg_wr_addr, cfg_wr_data}, 64'd0);
    check("R12 irq", {63'd0, irq}, 64'd0);
    check("R12 no response pending", {62'd0, bvalid, rvalid}, 64'd0);

    // R5 R10 R12 sweep of every word offset
    for (int off = 0; off <= 'h4C; off += 4) begin
      axi_rd(12'(off), rv);
      check($sformatf("R5/R10/R12 read sweep off=%0h", off), {32'd0, rv}, {32'd0, reset_view(off)});
    end
    axi_rd(12'h041, rv);
    check("R10 unaligned read zero", {32'd0, rv}, 64'd0);

    // R9 R7 every strobe pattern on the memory base low word
    for (int s = 0; s < 16; s++) begin
      pre  = 32'h5A5A_5A5A ^ 32'(s);
      d_in = 32'hA1B2_C3D4 + 32'(s * 'h0101);
      axi_wr(12'h040, pre, 4'hF);
      axi_wr(12'h040, d_in, 4'(s));
      expv = '0;
      for (int b = 0; b < 4; b++) expv[8*b +: 8] = s[b] ? d_in[8*b +: 8] : pre[8*b +: 8];
      axi_rd(12'h040, rv);
      check($sformatf("R9 strobe %0h readback", s), {32'd0, rv}, {32'd0, expv});
      check($sformatf("R9 strobe %0h mem_base low", s), {32'd0, mem_base[31:0]}, {32'd0, expv});
    end
    axi_wr(12'h044, 32'h89AB_CDEF, 4'hF);
    check("R7 mem_base high", {32'd0, mem_base[63:32]}, 64'h89AB_CDEF);
    axi_wr(12'h034, 32'h0BAD_F00D, 4'hF);
    axi_wr(12'h038, 32'h1357_9BDF, 4'hF);
    axi_rd(12'h034, rv); check("R7 scratch low", {32'd0, rv}, 64'h0BAD_F00D);
    axi_rd(12'h038, rv); check("R7 scratch high", {32'd0, rv}, 64'h1357_9BDF);

    // R10 R5 writes with no effect
    axi_wr(12'h048, 32'hDEAD_BEEF, 4'hF);
    axi_rd(12'h048, rv); check("R10 unmapped write ignored", {32'd0, rv}, 64'd0);
    axi_wr(12'h042, 32'hFFFF_FFFF, 4'hF);
    check("R10 unaligned write leaves mem_base", {32'd0, mem_base[63:32]}, 64'h89AB_CDEF);
    axi_wr(12'h010, 32'h0, 4'hF);
    axi_rd(12'h010, rv); check("R5 capability not writable", {32'd0, rv}, {32'd0, DEV[31:0]});

    // R6 indirect configuration write
    p0 = cfg_pulses;
    axi_wr(12'h028, 32'h0000_0123, 4'hF);
    check("R6 address write gives no strobe", 64'(cfg_pulses - p0), 64'd0);
    axi_wr(12'h02C, 32'hCAFE_F00D, 4'hF);
    check("R6 strobe after value write", {63'd0, snap_cval}, 64'd1);
    check("R6 strobe address/value", {snap_cadr, snap_cdat}, 64'h0000_0123_CAFE_F00D);
    check("R6 strobe one cycle", 64'(cfg_pulses - p0), 64'd1);
    axi_rd(12'h028, rv); check("R6 address offset reads zero", {32'd0, rv}, 64'd0);

    // R2 R4 control word and auto restart
    axi_wr(12'h000, 32'h81, 4'hF);
    check("R2 start set by write", {63'd0, core_start}, 64'd1);
    axi_rd(12'h000, rv); check("R2 control readback", {32'd0, rv}, 64'h85);
    pulse_ready();
    check("R4 ready keeps start with auto-restart", {63'd0, core_start}, 64'd1);
    axi_wr(12'h000, 32'h00, 4'hF);
    check("R2 writing 0 leaves start", {63'd0, core_start}, 64'd1);
    axi_rd(12'h000, rv); check("R2 auto-restart cleared", {32'd0, rv}, 64'h05);
    pulse_ready();
    check("R4 ready clears start", {63'd0, core_start}, 64'd0);
    axi_wr(12'h000, 32'h81, 4'hE);
    axi_rd(12'h000, rv); check("R9 lane 0 off leaves control", {32'd0, rv}, 64'h04);
    @(negedge clk); core_ready = 1'b1;
    axi_rd(12'h000, rv); check("R2 ready bit", {32'd0, rv}, 64'h0C);
    axi_wr(12'h000, 32'h01, 4'hF);
    check("R4 host write wins over reload", {63'd0, snap_start}, 64'd1);
    check("R4 reload after collision", {63'd0, core_start}, 64'd0);
    @(negedge clk); core_ready = 1'b0;

    // R3 done latch and read clear
    pulse_done();
    axi_rd(12'h000, rv); check("R3 done latched", {32'd0, rv}, 64'h06);
    axi_rd(12'h000, rv); check("R3 done cleared by read", {32'd0, rv}, 64'h04);
    @(negedge clk); core_done = 1'b1;
    axi_rd(12'h000, rv); check("R3 set wins first read", {32'd0, rv}, 64'h06);
    axi_rd(12'h000, rv); check("R3 set wins second read", {32'd0, rv}, 64'h06);
    @(negedge clk); core_done = 1'b0;
    axi_rd(12'h000, rv); check("R3 last read after release", {32'd0, rv}, 64'h06);
    axi_rd(12'h000, rv); check("R3 cleared after release", {32'd0, rv}, 64'h04);

    // R8 interrupts
    axi_wr(12'h008, 32'h1, 4'hF);
    axi_wr(12'h004, 32'h1, 4'hF);
    axi_rd(12'h004, rv); check("R8 global enable readback", {32'd0, rv}, 64'd1);
    axi_rd(12'h008, rv); check("R8 enable readback", {32'd0, rv}, 64'd1);
    pulse_done();
    check("R8 irq on done edge", {63'd0, irq}, 64'd1);
    axi_rd(12'h00C, rv); check("R8 status set", {32'd0, rv}, 64'd1);
    axi_wr(12'h00C, 32'h0, 4'hF);
    check("R8 writing 0 keeps status", {63'd0, irq}, 64'd1);
    axi_wr(12'h00C, 32'h1, 4'hF);
    check("R8 write one clears", {63'd0, irq}, 64'd0);
    axi_wr(12'h004, 32'h0, 4'hF);
    pulse_done();
    check("R8 irq masked by global enable", {63'd0, irq}, 64'd0);
    axi_rd(12'h00C, rv); check("R8 status set while masked", {32'd0, rv}, 64'd1);
    axi_wr(12'h004, 32'h1, 4'hF);
    check("R8 irq on global enable", {63'd0, irq}, 64'd1);
    axi_wr(12'h00C, 32'h1, 4'hF);
    @(negedge clk); core_done = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 irq with done held", {63'd0, irq}, 64'd1);
    axi_wr(12'h00C, 32'h1, 4'hF);
    repeat (3) @(negedge clk);
    check("R8 level raises no second edge", {63'd0, irq}, 64'd0);
    core_done = 1'b0;
    axi_wr(12'h008, 32'h0, 4'hF);
    pulse_done();
    axi_rd(12'h00C, rv); check("R8 no status with enable off", {32'd0, rv}, 64'd0);
    axi_rd(12'h000, rv);

    // R11 clock enable freeze
    axi_wr(12'h008, 32'h1, 4'hF);
    axi_wr(12'h000, 32'h01, 4'hF);
    @(negedge clk);
    clk_en = 1'b0; core_ready = 1'b1; core_done = 1'b1;
    awaddr = 12'h040; wdata = 32'h0; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    check("R11 no write accept while disabled", {63'd0, awready}, 64'd0);
    repeat (2) @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0; core_ready = 1'b0; core_done = 1'b0;
    @(negedge clk);
    clk_en = 1'b1;
    check("R11 start held", {63'd0, core_start}, 64'd1);
    check("R11 irq held", {63'd0, irq}, 64'd0);
    check("R11 mem_base held", {32'd0, mem_base[63:32]}, 64'h89AB_CDEF);
    axi_rd(12'h000, rv); check("R11 done not latched", {32'd0, rv}, 64'h05);

    // R1 held read response and write needing both channels
    @(negedge clk);
    araddr = 12'h014; arvalid = 1'b1; rready = 1'b0; #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    check("R1 rvalid held", {63'd0, rvalid}, 64'd1);
    check("R1 no second read accepted", {63'd0, arready}, 64'd0);
    check("R1 held data", {32'd0, rdata}, {32'd0, DEV[63:32]});
    arvalid = 1'b0; rready = 1'b1;
    @(negedge clk); rready = 1'b0;
    check("R1 response taken", {63'd0, rvalid}, 64'd0);
    awaddr = 12'h040; awvalid = 1'b1; wvalid = 1'b0; #1;
    check("R1 address alone not accepted", {63'd0, awready}, 64'd0);
    @(negedge clk); awvalid = 1'b0;

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule